// File: doc/BRIEF.md
# Delay-Slot Illegal Instruction Trap

This block sits beside the decode stage of a small RISC pipeline whose branches are delayed: the instruction fetched right after a delayed branch, the delay slot, executes before the branch target. Some instructions are legal anywhere except in that slot. The block keeps a one-bit record of whether the instruction now being decoded occupies a delay slot. It checks that instruction against the categories the slot forbids: the reserved undefined opcode, anything that writes the program counter, a privileged instruction issued in user mode, and PC-relative data accesses.

On a violation it raises a trap pulse in the same cycle. In that cycle it also drives every value the exception entry must commit. The saved PC points at the delayed branch, one instruction back, and not at the faulting instruction. The old status word and the stack pointer (R15) are saved. It also drives a fixed event code, a new status word with the mode, bank and block bits forced on, and a fetch address at a fixed offset from the vector base. The surrounding pipeline uses the pulse to squash the faulting instruction and commit these values.

The opcode is compared directly against the reserved code. All other categories arrive as class flags from the main decoder.

Top module: `dslot_trap`

## Requirements
- R1: After synchronous reset, slot_o is 0 and trap_o is 0.
- R2: An accepted instruction (ins_valid_i=1) with ins_dly_branch_i=1 that does not trap sets slot_o from the next cycle. Cycles with ins_valid_i=0 keep slot_o unchanged. The next accepted instruction clears slot_o unless it sets it again, and a trapped delayed branch never sets it.
- R3: In a delay slot, ins_opcode_i equal to 16'hFFFD raises trap_o, whatever the class flags are.
- R4: In a delay slot, an instruction with ins_dly_branch_i=1 or ins_pc_write_i=1 raises trap_o.
- R5: In a delay slot, ins_priv_i=1 with ins_priv_exempt_i=0 raises trap_o only when cur_sr_i bit 30 (mode bit) is 0. With ins_priv_exempt_i=1 it never traps.
- R6: In a delay slot, ins_pc_rel_i=1 raises trap_o.
- R7: Outside a delay slot, or with ins_valid_i=0, trap_o stays 0 for every opcode and flag pattern.
- R8: While trap_o=1, sav_pc_o equals cur_pc_i minus 2 (modulo 2^32), sav_sr_o equals cur_sr_i and sav_gr_o equals cur_r15_i.
- R9: While trap_o=1, evt_code_o equals 32'h000001A0.
- R10: While trap_o=1, new_sr_o equals cur_sr_i with bits 30, 29 and 28 set to 1. new_pc_o equals cur_vbr_i plus 32'h100 (modulo 2^32).
- R11: trap_o is a combinational same-cycle result of the instruction being decoded. While trap_o=0, all six entry outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid_i | input | 1 | An instruction is decoded and consumed this cycle |
| ins_opcode_i | input | 16 | Raw opcode of the instruction |
| ins_dly_branch_i | input | 1 | Instruction is a delayed branch |
| ins_pc_write_i | input | 1 | Instruction writes PC without a delay slot (conditional branch, trap, status load) |
| ins_priv_i | input | 1 | Instruction is privileged |
| ins_priv_exempt_i | input | 1 | Privileged form that targets the global base register, always allowed |
| ins_pc_rel_i | input | 1 | PC-relative data load or address calculation |
| cur_pc_i | input | 32 | Address of the decoded instruction |
| cur_sr_i | input | 32 | Current status word |
| cur_r15_i | input | 32 | Current stack pointer |
| cur_vbr_i | input | 32 | Vector base address |
| slot_o | output | 1 | Decoded instruction occupies a delay slot |
| trap_o | output | 1 | Slot-illegal exception pulse |
| sav_pc_o | output | 32 | Saved PC value |
| sav_sr_o | output | 32 | Saved status value |
| sav_gr_o | output | 32 | Saved stack-pointer value |
| evt_code_o | output | 32 | Exception event code |
| new_sr_o | output | 32 | Status word after entry |
| new_pc_o | output | 32 | Next fetch address |

## Verification
The bench sweeps every forbidden category and two legal patterns, each inside and outside a delay slot and in both privilege modes. A design that ignored the slot flag would trap on ordinary branches. One that read the mode bit backwards would trap kernel code and let user code through. It also checks the exempt privileged form and a non-trapping delayed branch followed by idle cycles. A tracker that cleared on invalid cycles, or never cleared, would fail those checks. So would one that let a trapped branch open a new slot. Entry values use wrapping addresses (PC of zero, vector base near the top), which catches an off-by-one saved PC or a non-wrapping adder.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    localparam int XLEN = 32;
    localparam int ILEN = 16;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [ILEN-1:0] opcode_t;

    typedef struct packed {
        logic dly_branch;
        logic pc_write;
        logic priv;
        logic priv_exempt;
        logic pc_rel;
    } ins_class_t;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_UNDEF = 3'd1,
        CAUSE_PCMOD = 3'd2,
        CAUSE_PRIV  = 3'd3,
        CAUSE_PCREL = 3'd4
    } cause_e;

    typedef struct packed {
        word_t sav_pc;
        word_t sav_sr;
        word_t sav_gr;
        word_t evt_code;
        word_t new_sr;
        word_t new_pc;
    } entry_t;

    function automatic word_t bit_mask3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
        word_t m;
        m = '0;
        m[a] = 1'b1;
        m[b] = 1'b1;
        m[c] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dslot_tracker.sv
module dslot_tracker (
    input  logic clk,
    input  logic rst,
    input  logic valid_i,
    input  logic dly_branch_i,
    input  logic trap_i,
    output logic slot_o
);
    logic slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= 1'b0;
        end else if (valid_i) begin
            slot_q <= dly_branch_i & ~trap_i;
        end
    end

    assign slot_o = slot_q;

    // R2: a slot opens only after an accepted, untrapped delayed branch
    assert_slot_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_q) |-> $past(valid_i && dly_branch_i && !trap_i));

    // R2: an instruction consumed in a slot always closes it
    assert_slot_closes_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_q && valid_i) |=> !slot_q);

    // R2: idle cycles leave the flag alone
    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(slot_q));

endmodule

// File: rtl/dslot_classify.sv
module dslot_classify
    import dslot_pkg::*;
#(
    parameter opcode_t UNDEF_OP = 16'hFFFD
) (
    input  logic       valid_i,
    input  logic       in_slot_i,
    input  logic       user_mode_i,
    input  opcode_t    opcode_i,
    input  ins_class_t cls_i,
    output logic       violate_o
);
    cause_e cause;

    always_comb begin
        cause = CAUSE_NONE;
        if (valid_i && in_slot_i) begin
            if (opcode_i == UNDEF_OP) begin
                cause = CAUSE_UNDEF;
            end else if (cls_i.dly_branch || cls_i.pc_write) begin
                cause = CAUSE_PCMOD;
            end else if (cls_i.priv && !cls_i.priv_exempt && user_mode_i) begin
                cause = CAUSE_PRIV;
            end else if (cls_i.pc_rel) begin
                cause = CAUSE_PCREL;
            end
        end
    end

    assign violate_o = (cause != CAUSE_NONE);

    // R7: no violation without an accepted slot instruction
    always_comb begin
        if (!(valid_i && in_slot_i)) begin
            assert_no_trap_outside_R7: assert (!violate_o);
        end
    end

endmodule

// File: rtl/dslot_entry.sv
module dslot_entry
    import dslot_pkg::*;
#(
    parameter int    INSN_BYTES = 2,
    parameter word_t EVT_CODE   = 32'h0000_01A0,
    parameter word_t VEC_OFS    = 32'h0000_0100,
    parameter int    MD_BIT     = 30,
    parameter int    RB_BIT     = 29,
    parameter int    BL_BIT     = 28
) (
    input  logic   fire_i,
    input  word_t  pc_i,
    input  word_t  sr_i,
    input  word_t  r15_i,
    input  word_t  vbr_i,
    output entry_t entry_o
);
    localparam word_t FORCE_MASK = bit_mask3(MD_BIT, RB_BIT, BL_BIT);
    localparam word_t STEP       = word_t'(INSN_BYTES);

    always_comb begin
        entry_o = '0;
        if (fire_i) begin
            entry_o.sav_pc   = pc_i - STEP;
            entry_o.sav_sr   = sr_i;
            entry_o.sav_gr   = r15_i;
            entry_o.evt_code = EVT_CODE;
            entry_o.new_sr   = sr_i | FORCE_MASK;
            entry_o.new_pc   = vbr_i + VEC_OFS;
        end
    end

endmodule

// File: rtl/dslot_trap.sv
module dslot_trap
    import dslot_pkg::*;
#(
    parameter opcode_t UNDEF_OP   = 16'hFFFD,
    parameter int      INSN_BYTES = 2,
    parameter word_t   EVT_CODE   = 32'h0000_01A0,
    parameter word_t   VEC_OFS    = 32'h0000_0100,
    parameter int      MD_BIT     = 30,
    parameter int      RB_BIT     = 29,
    parameter int      BL_BIT     = 28
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ins_valid_i,
    input  logic [15:0] ins_opcode_i,
    input  logic        ins_dly_branch_i,
    input  logic        ins_pc_write_i,
    input  logic        ins_priv_i,
    input  logic        ins_priv_exempt_i,
    input  logic        ins_pc_rel_i,
    input  logic [31:0] cur_pc_i,
    input  logic [31:0] cur_sr_i,
    input  logic [31:0] cur_r15_i,
    input  logic [31:0] cur_vbr_i,
    output logic        slot_o,
    output logic        trap_o,
    output logic [31:0] sav_pc_o,
    output logic [31:0] sav_sr_o,
    output logic [31:0] sav_gr_o,
    output logic [31:0] evt_code_o,
    output logic [31:0] new_sr_o,
    output logic [31:0] new_pc_o
);
    ins_class_t cls;
    entry_t     entry;
    logic       in_slot;
    logic       user_mode;

    assign cls = '{dly_branch:  ins_dly_branch_i,
                   pc_write:    ins_pc_write_i,
                   priv:        ins_priv_i,
                   priv_exempt: ins_priv_exempt_i,
                   pc_rel:      ins_pc_rel_i};

    assign user_mode = ~cur_sr_i[MD_BIT];

    dslot_tracker u_tracker (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (ins_valid_i),
        .dly_branch_i (ins_dly_branch_i),
        .trap_i       (trap_o),
        .slot_o       (in_slot)
    );

    dslot_classify #(.UNDEF_OP(UNDEF_OP)) u_classify (
        .valid_i     (ins_valid_i),
        .in_slot_i   (in_slot),
        .user_mode_i (user_mode),
        .opcode_i    (ins_opcode_i),
        .cls_i       (cls),
        .violate_o   (trap_o)
    );

    dslot_entry #(
        .INSN_BYTES (INSN_BYTES),
        .EVT_CODE   (EVT_CODE),
        .VEC_OFS    (VEC_OFS),
        .MD_BIT     (MD_BIT),
        .RB_BIT     (RB_BIT),
        .BL_BIT     (BL_BIT)
    ) u_entry (
        .fire_i  (trap_o),
        .pc_i    (cur_pc_i),
        .sr_i    (cur_sr_i),
        .r15_i   (cur_r15_i),
        .vbr_i   (cur_vbr_i),
        .entry_o (entry)
    );

    assign slot_o     = in_slot;
    assign sav_pc_o   = entry.sav_pc;
    assign sav_sr_o   = entry.sav_sr;
    assign sav_gr_o   = entry.sav_gr;
    assign evt_code_o = entry.evt_code;
    assign new_sr_o   = entry.new_sr;
    assign new_pc_o   = entry.new_pc;

    // R11: a trap only happens while the slot flag is up
    assert_trap_in_slot_R11: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> slot_o);

    // R8: saved PC points one instruction back
    assert_saved_pc_R8: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (sav_pc_o + 32'(INSN_BYTES) == cur_pc_i));

    // R10: the entry status word has mode, bank and block bits on
    assert_new_sr_bits_R10: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (new_sr_o[MD_BIT] && new_sr_o[RB_BIT] && new_sr_o[BL_BIT]));

    // R11: entry outputs are quiet without a trap
    assert_quiet_entry_R11: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> (new_pc_o == '0 && evt_code_o == '0 && sav_pc_o == '0));

    // R5: user/privileged distinction for privileged instructions
    assert_priv_kernel_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_o && ins_valid_i && cur_sr_i[MD_BIT] && ins_opcode_i != UNDEF_OP &&
         !ins_dly_branch_i && !ins_pc_write_i && !ins_pc_rel_i) |-> !trap_o);

endmodule

// File: tb/dslot_trap_tb.sv
module dslot_trap_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid_i = 1'b0;
    logic [15:0] ins_opcode_i = 16'h0009;
    logic        ins_dly_branch_i = 1'b0;
    logic        ins_pc_write_i = 1'b0;
    logic        ins_priv_i = 1'b0;
    logic        ins_priv_exempt_i = 1'b0;
    logic        ins_pc_rel_i = 1'b0;
    logic [31:0] cur_pc_i = '0;
    logic [31:0] cur_sr_i = '0;
    logic [31:0] cur_r15_i = '0;
    logic [31:0] cur_vbr_i = '0;
    logic        slot_o;
    logic        trap_o;
    logic [31:0] sav_pc_o, sav_sr_o, sav_gr_o, evt_code_o, new_sr_o, new_pc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dslot_trap dut_i (
        .clk(clk), .rst(rst), .ins_valid_i(ins_valid_i), .ins_opcode_i(ins_opcode_i),
        .ins_dly_branch_i(ins_dly_branch_i), .ins_pc_write_i(ins_pc_write_i),
        .ins_priv_i(ins_priv_i), .ins_priv_exempt_i(ins_priv_exempt_i),
        .ins_pc_rel_i(ins_pc_rel_i), .cur_pc_i(cur_pc_i), .cur_sr_i(cur_sr_i),
        .cur_r15_i(cur_r15_i), .cur_vbr_i(cur_vbr_i), .slot_o(slot_o), .trap_o(trap_o),
        .sav_pc_o(sav_pc_o), .sav_sr_o(sav_sr_o), .sav_gr_o(sav_gr_o),
        .evt_code_o(evt_code_o), .new_sr_o(new_sr_o), .new_pc_o(new_pc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] op, input int cat);
        ins_valid_i       = v;
        ins_opcode_i      = op;
        ins_dly_branch_i  = (cat == 2);
        ins_pc_write_i    = (cat == 3);
        ins_priv_i        = (cat == 4) || (cat == 5);
        ins_priv_exempt_i = (cat == 5);
        ins_pc_rel_i      = (cat == 6);
    endtask

    // cat: 0 plain, 1 undefined opcode, 2 delayed branch, 3 PC write,
    //      4 privileged, 5 exempt privileged, 6 PC-relative
    task automatic run_case(input int cat, input bit in_slot, input bit user,
                            input logic [31:0] pc, input logic [31:0] sr_base,
                            input logic [31:0] r15, input logic [31:0] vbr);
        logic        exp_trap;
        logic [31:0] sr;
        string       tag;
        sr = user ? (sr_base & ~32'h4000_0000) : (sr_base | 32'h4000_0000);
        @(negedge clk);
        drive(1'b1, 16'h0009, 0);              // plain instruction closes any slot
        if (in_slot) begin
            @(negedge clk);
            drive(1'b1, 16'h0009, 2);          // opens a slot
        end
        @(negedge clk);
        drive(1'b1, (cat == 1) ? 16'hFFFD : 16'h0009, cat);
        cur_pc_i = pc; cur_sr_i = sr; cur_r15_i = r15; cur_vbr_i = vbr;
        #2;
        exp_trap = in_slot && (cat == 1 || cat == 2 || cat == 3 || cat == 6 ||
                               (cat == 4 && user));
        case (cat)
            1: tag = "R3";
            2, 3: tag = "R4";
            4, 5: tag = "R5";
            6: tag = "R6";
            default: tag = "R7";
        endcase
        if (!in_slot) tag = "R7";
        check(tag, {31'b0, trap_o}, {31'b0, exp_trap});
        check("R2 slot flag during case", {31'b0, slot_o}, {31'b0, in_slot});
        if (exp_trap) begin
            check("R8 saved pc", sav_pc_o, pc - 32'd2);
            check("R8 saved sr", sav_sr_o, sr);
            check("R8 saved r15", sav_gr_o, r15);
            check("R9 event code", evt_code_o, 32'h0000_01A0);
            check("R10 new sr", new_sr_o, sr | 32'h7000_0000);
            check("R10 new pc", new_pc_o, vbr + 32'h0000_0100);
        end else begin
            check("R11 quiet new pc", new_pc_o, 32'h0);
            check("R11 quiet event", evt_code_o, 32'h0);
            check("R11 quiet saved sr", sav_sr_o, 32'h0);
        end
        @(negedge clk);
        drive(1'b0, 16'h0009, 0);
        check("R2 slot after case", {31'b0, slot_o}, {31'b0, (cat == 2) && !exp_trap});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R0 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #2;
        check("R1 reset slot", {31'b0, slot_o}, 32'h0);
        check("R1 reset trap", {31'b0, trap_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int cat = 0; cat < 7; cat++) begin
            for (int s = 0; s < 2; s++) begin
                for (int u = 0; u < 2; u++) begin
                    int idx;
                    idx = cat * 4 + s * 2 + u;
                    run_case(cat, s[0], u[0],
                             32'h1000_0000 + idx * 6,
                             32'h0000_00F0 ^ (idx << 8),
                             32'hCAFE_0000 + idx,
                             32'h8000_0000 + idx * 32'h400);
                end
            end
        end

        // wrapping arithmetic on the entry values
        run_case(1, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0003, 32'h1234_5678, 32'hFFFF_FF80);
        run_case(6, 1'b1, 1'b0, 32'h0000_0001, 32'h8F00_0000, 32'h0, 32'hFFFF_FF00);

        // R2: slot held across idle cycles, then consumed by a trapping opcode
        @(negedge clk);
        drive(1'b1, 16'h0009, 0);
        @(negedge clk);
        drive(1'b1, 16'h0009, 2);
        @(negedge clk);
        drive(1'b0, 16'hFFFD, 0);
        #2;
        check("R7 invalid undef opcode no trap", {31'b0, trap_o}, 32'h0);
        repeat (3) @(negedge clk);
        check("R2 slot held while idle", {31'b0, slot_o}, 32'h1);
        drive(1'b1, 16'hFFFD, 0);
        cur_pc_i = 32'h0000_4002; cur_sr_i = 32'h4000_0000;
        cur_r15_i = 32'h0BAD_F00D; cur_vbr_i = 32'h0000_0000;
        #2;
        check("R3 undef after idle", {31'b0, trap_o}, 32'h1);
        check("R8 saved pc after idle", sav_pc_o, 32'h0000_4000);
        @(negedge clk);
        drive(1'b0, 16'h0009, 0);
        check("R2 slot closed after trap", {31'b0, slot_o}, 32'h0);

        // R2: two delayed branches back to back, the second traps and opens nothing
        @(negedge clk);
        drive(1'b1, 16'h0009, 2);
        @(negedge clk);
        drive(1'b1, 16'h0009, 2);
        #2;
        check("R4 branch in slot", {31'b0, trap_o}, 32'h1);
        @(negedge clk);
        drive(1'b1, 16'h0009, 2);
        #2;
        check("R2 trapped branch opened no slot", {31'b0, trap_o}, 32'h0);
        @(negedge clk);
        drive(1'b0, 16'h0009, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule